// File: doc/BRIEF.md
# Latched 64-bit Match Timer

This block is a system timer built around a free-running 64-bit tick counter. A programmable prescaler turns the input clock into ticks, and the counter advances by one on each tick. Software can preset either half of the count at any time, for example to clear it to zero. Because a 64-bit value cannot be read in one 32-bit bus access without tearing, software first writes a snapshot command. The whole count is then copied into a pair of held registers, which it reads at leisure.

Six 32-bit compare channels watch the low word of the counter. When the counter steps onto a channel's compare value, that channel raises a sticky event flag. Software clears the flag by writing a one to it. A per-channel enable mask routes the flags onto a single registered interrupt line. The highest channel can also drive a watchdog reset output when a one-bit watchdog arm register is set.

The register bus is a simple single-cycle 32-bit port. Writes take effect on the clock edge where the write enable is high. Read data is a combinational function of the address.

Top module: `latched_match_timer`

## Requirements
- R1: After reset the counter, event flags, enable mask, watchdog arm and divider read zero, every compare register reads 0xFFFFFFFF, and both irq and wdt_rst are low.
- R2: With divider value D, the counter advances by exactly one every 2*(D+1) clock cycles, and a carry out of the low word propagates into the high word.
- R3: A write to the divider, the counter low word (0x00) or the counter high word (0x04) restarts the tick phase, so the next tick comes a full period after that edge. A counter word write replaces that half of the count and overrides a tick in the same cycle.
- R4: A write to 0x30 with bit 0 set copies the count held just before that edge into the snapshot registers (low word at 0x34, high word at 0x38). These keep that value while the counter runs on. A write to 0x30 with bit 0 clear has no effect.
- R5: Event flag n (bit n at 0x20) sets on the edge where a tick moves the counter's low word onto compare value n (channel n at 0x08 + 4*n). A preset write that loads the matching value does not set it, and a compare value that has already been passed does not fire again.
- R6: Writing 0x20 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R7: If a flag is set by a compare hit and cleared by a write in the same cycle, the flag ends up set.
- R8: irq is high one cycle after any flag whose enable bit (bit n at 0x24) is set. Clearing the enable bit drops irq and leaves the flag itself in place.
- R9: While bit 0 of the watchdog arm register (0x28) is 1, flag 5 drives wdt_rst high one cycle later. With the arm bit 0, wdt_rst stays low even when flag 5 is set.
- R10: The divider sits at 0x2C, and reads of 0x30 return zero. An access whose address has either of its two low bits set selects no register: it reads zero and its write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Registered interrupt request |
| wdt_rst | output | 1 | Registered watchdog reset request |

## Verification
There are two collision cases. A compare hit and a software clear of the same event flag can land on one clock edge. A counter preset can also coincide with a would-be tick.

For the first case, the bench presets the counter with divider zero, so ticks fall on every second edge. It then counts edges so that the clear write lands on the same edge where the counter steps onto the compare value. The flag must read back as set. A later clear with no hit must then empty it.

For the second case, a preset to the compare value itself must leave the flag clear. Both rules are also watched every cycle by properties relating the hit vector to the flag register.

// File: rtl/lmt_pkg.sv
`timescale 1ns/1ps
package lmt_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 2 * DATA_W;
    localparam int NUM_CH    = 6;
    localparam int WD_CH     = NUM_CH - 1;
    localparam int DIV_W     = 32;
    localparam int ADDR_W    = 6;
    localparam int REG_IDX_W = ADDR_W - 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_CNT_LO  = 4'd0,
        REG_CNT_HI  = 4'd1,
        REG_CMP0    = 4'd2,
        REG_CMP1    = 4'd3,
        REG_CMP2    = 4'd4,
        REG_CMP3    = 4'd5,
        REG_CMP4    = 4'd6,
        REG_CMP5    = 4'd7,
        REG_EVT     = 4'd8,
        REG_EVT_EN  = 4'd9,
        REG_WD_ARM  = 4'd10,
        REG_DIV     = 4'd11,
        REG_SNAP    = 4'd12,
        REG_SNAP_LO = 4'd13,
        REG_SNAP_HI = 4'd14,
        REG_NONE    = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic                  cnt_lo;
        logic                  cnt_hi;
        logic [NUM_CH-1:0]     cmp;
        logic                  evt_clr;
        logic                  evt_en;
        logic                  wd_arm;
        logic                  div;
        logic                  snap;
    } wr_strobe_t;

    function automatic reg_idx_e cmp_idx(input int n);
        return reg_idx_e'(REG_IDX_W'(int'(REG_CMP0) + n));
    endfunction

    function automatic reg_idx_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)
            return REG_NONE;
        return reg_idx_e'(a[ADDR_W-1:2]);
    endfunction
endpackage

// File: rtl/lmt_prescaler.sv
`timescale 1ns/1ps
module lmt_prescaler #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             restart,
    output logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] limit;

    // a period of 2*(D+1) cycles ends when the phase reaches 2*D+1
    assign limit = {div, 1'b1};
    assign tick  = !restart && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            div <= '0;
        end else if (div_we) begin
            div <= div_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (restart || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/lmt_counter.sv
`timescale 1ns/1ps
module lmt_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                snap_cmd,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] cnt,
    output logic [2*DATA_W-1:0] snap,
    output logic                step,
    output logic [DATA_W-1:0]   next_lo
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + CNT_W'(1);
    assign step    = tick && !wr_lo && !wr_hi;
    assign next_lo = cnt_inc[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:DATA_W] <= wdata;
        end else if (step) begin
            cnt <= cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (snap_cmd) begin
            snap <= cnt;
        end
    end
endmodule

// File: rtl/lmt_match_bank.sv
`timescale 1ns/1ps
module lmt_match_bank #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             cmp_we,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          step,
    input  logic [DATA_W-1:0]             next_lo,
    output logic [NUM_CH-1:0][DATA_W-1:0] cmp,
    output logic [NUM_CH-1:0]             hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_CH; n++) cmp[n] <= '1;
        end else begin
            for (int n = 0; n < NUM_CH; n++)
                if (cmp_we[n]) cmp[n] <= wdata;
        end
    end

    // only a tick landing on the value counts; presets never do
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        assign hit[g] = step && (next_lo == cmp[g]);
    end
endmodule

// File: rtl/lmt_event_ctrl.sv
`timescale 1ns/1ps
module lmt_event_ctrl #(
    parameter int NUM_CH = 6,
    parameter int WD_CH  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic              arm_we,
    input  logic [NUM_CH-1:0] wmask,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] evt_en,
    output logic              wd_arm,
    output logic              irq,
    output logic              wdt_rst
);
    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = clr_we ? wmask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            evt_en <= '0;
            wd_arm <= 1'b0;
        end else begin
            status <= (status & ~clr_mask) | hit;
            if (en_we)  evt_en <= wmask;
            if (arm_we) wd_arm <= wmask[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            wdt_rst <= 1'b0;
        end else begin
            irq     <= |(status & evt_en);
            wdt_rst <= wd_arm && status[WD_CH];
        end
    end
endmodule

// File: rtl/latched_match_timer.sv
`timescale 1ns/1ps
module latched_match_timer
    import lmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_rst
);
    reg_idx_e                    idx;
    wr_strobe_t                  wr;
    logic                        tick;
    logic                        step;
    logic                        restart;
    logic [DIV_W-1:0]            div;
    logic [CNT_W-1:0]            cnt;
    logic [CNT_W-1:0]            snap;
    logic [DATA_W-1:0]           next_lo;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp;
    logic [NUM_CH-1:0]           hit;
    logic [NUM_CH-1:0]           status;
    logic [NUM_CH-1:0]           evt_en;
    logic                        wd_arm;
    logic                        cnt_wr;

    assign idx = decode_addr(bus_addr);

    always_comb begin
        wr         = '0;
        wr.cnt_lo  = bus_we && (idx == REG_CNT_LO);
        wr.cnt_hi  = bus_we && (idx == REG_CNT_HI);
        wr.evt_clr = bus_we && (idx == REG_EVT);
        wr.evt_en  = bus_we && (idx == REG_EVT_EN);
        wr.wd_arm  = bus_we && (idx == REG_WD_ARM);
        wr.div     = bus_we && (idx == REG_DIV);
        wr.snap    = bus_we && (idx == REG_SNAP) && bus_wdata[0];
        for (int n = 0; n < NUM_CH; n++)
            wr.cmp[n] = bus_we && (idx == cmp_idx(n));
    end

    assign cnt_wr  = wr.cnt_lo || wr.cnt_hi;
    assign restart = wr.div || cnt_wr;

    lmt_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk       (clk),
        .rst       (rst),
        .div_we    (wr.div),
        .div_wdata (bus_wdata[DIV_W-1:0]),
        .restart   (restart),
        .div       (div),
        .tick      (tick)
    );

    lmt_counter #(.DATA_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_lo    (wr.cnt_lo),
        .wr_hi    (wr.cnt_hi),
        .snap_cmd (wr.snap),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .snap     (snap),
        .step     (step),
        .next_lo  (next_lo)
    );

    lmt_match_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .cmp_we  (wr.cmp),
        .wdata   (bus_wdata),
        .step    (step),
        .next_lo (next_lo),
        .cmp     (cmp),
        .hit     (hit)
    );

    lmt_event_ctrl #(.NUM_CH(NUM_CH), .WD_CH(WD_CH)) u_event (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .clr_we  (wr.evt_clr),
        .en_we   (wr.evt_en),
        .arm_we  (wr.wd_arm),
        .wmask   (bus_wdata[NUM_CH-1:0]),
        .status  (status),
        .evt_en  (evt_en),
        .wd_arm  (wd_arm),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            REG_CNT_LO:  bus_rdata = cnt[DATA_W-1:0];
            REG_CNT_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
            REG_EVT:     bus_rdata = DATA_W'(status);
            REG_EVT_EN:  bus_rdata = DATA_W'(evt_en);
            REG_WD_ARM:  bus_rdata = DATA_W'(wd_arm);
            REG_DIV:     bus_rdata = DATA_W'(div);
            REG_SNAP_LO: bus_rdata = snap[DATA_W-1:0];
            REG_SNAP_HI: bus_rdata = snap[CNT_W-1:DATA_W];
            default: begin
                for (int n = 0; n < NUM_CH; n++)
                    if (idx == cmp_idx(n)) bus_rdata = cmp[n];
            end
        endcase
    end
endmodule

// File: rtl/lmt_checker.sv
`timescale 1ns/1ps
module lmt_checker
    import lmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  snap,
    input logic              snap_cmd,
    input logic              step,
    input logic              cnt_wr,
    input logic [NUM_CH-1:0] hit,
    input logic [NUM_CH-1:0] status,
    input logic [NUM_CH-1:0] evt_en,
    input logic              clr_we,
    input logic [NUM_CH-1:0] clr_mask,
    input logic              wd_arm,
    input logic              irq,
    input logic              wdt_rst
);
    a_r2_step_adds_one: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!step && !cnt_wr) |=> $stable(cnt));

    a_r4_snap_takes_count: assert property (@(posedge clk) disable iff (rst)
        snap_cmd |=> (snap == $past(cnt)));

    a_r4_snap_holds: assert property (@(posedge clk) disable iff (rst)
        !snap_cmd |=> $stable(snap));

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr_we && (hit == '0)) |=> ((status & $past(clr_mask)) == '0));

    a_r7_hit_wins: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

    a_r8_irq_raise: assert property (@(posedge clk) disable iff (rst)
        (|(status & evt_en)) |=> irq);

    a_r8_irq_drop: assert property (@(posedge clk) disable iff (rst)
        !(|(status & evt_en)) |=> !irq);

    a_r9_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        !wd_arm |=> !wdt_rst);
endmodule

bind latched_match_timer lmt_checker u_lmt_checker (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .snap     (snap),
    .snap_cmd (wr.snap),
    .step     (step),
    .cnt_wr   (cnt_wr),
    .hit      (hit),
    .status   (status),
    .evt_en   (evt_en),
    .clr_we   (wr.evt_clr),
    .clr_mask (bus_wdata[lmt_pkg::NUM_CH-1:0]),
    .wd_arm   (wd_arm),
    .irq      (irq),
    .wdt_rst  (wdt_rst)
);

// File: tb/latched_match_timer_bench.sv
`timescale 1ns/1ps
module latched_match_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wdt_rst;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      rd_ev;

    always #10 clk = ~clk;

    latched_match_timer u_latched_match_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdt_rst   (wdt_rst)
    );

    // monitor: pops the expected item and judges the read data
    always @(rd_ev) begin
        exp_item_t it;
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s: addr 0x%02h actual 0x%08h expected 0x%08h",
                     it.tag, it.addr, bus_rdata, it.exp);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        exp_q.push_back(it);
        #2;
        -> rd_ev;
        #1;
    endtask

    task automatic pin(input logic act, input logic e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        pin(irq, 1'b0, "R1 irq");
        pin(wdt_rst, 1'b0, "R1 wdt_rst");
        rd(6'h20, 32'h0, "R1 flags");
        rd(6'h24, 32'h0, "R1 enable");
        rd(6'h28, 32'h0, "R1 arm");
        rd(6'h2C, 32'h0, "R1 divider");
        rd(6'h08, 32'hFFFF_FFFF, "R1 compare0");
        rd(6'h1C, 32'hFFFF_FFFF, "R1 compare5");
        rd(6'h34, 32'h0, "R1 snapshot");

        // R3 / R10 preset with a slow divider
        wr(6'h2C, 32'd1000);
        rd(6'h2C, 32'd1000, "R10 divider readback");
        wr(6'h04, 32'h1234_5678);
        wr(6'h00, 32'hFFFF_FFF0);
        rd(6'h00, 32'hFFFF_FFF0, "R3 preset low");
        rd(6'h04, 32'h1234_5678, "R3 preset high");
        rd(6'h30, 32'h0, "R10 command reads zero");
        rd(6'h09, 32'h0, "R10 misaligned read");
        wr(6'h01, 32'h0);
        rd(6'h00, 32'hFFFF_FFF0, "R10 misaligned write ignored");
        wr(6'h30, 32'h1);
        rd(6'h34, 32'hFFFF_FFF0, "R4 snapshot low");
        rd(6'h38, 32'h1234_5678, "R4 snapshot high");

        // R2 carry: D=0, preset low to all ones, one tick before snapshot
        wr(6'h2C, 32'd0);
        wr(6'h00, 32'hFFFF_FFFF);
        idle(1);
        wr(6'h30, 32'h1);
        rd(6'h34, 32'h0, "R2 carry low");
        rd(6'h38, 32'h1234_5679, "R2 carry high");

        // R2 / R3 period 2*(3+1)=8 cycles
        wr(6'h2C, 32'd3);
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h0);
        idle(38);
        wr(6'h30, 32'h1);
        rd(6'h34, 32'd4, "R2 period just before fifth tick");
        wr(6'h00, 32'h0);
        idle(39);
        wr(6'h30, 32'h1);
        rd(6'h34, 32'd5, "R2 period at fifth tick");
        rd(6'h38, 32'd0, "R2 period high");
        idle(100);
        rd(6'h34, 32'd5, "R4 snapshot holds while counting");
        wr(6'h30, 32'h2);
        rd(6'h34, 32'd5, "R4 bit0 clear ignored");

        // R5 / R6 / R8 compare channel 2
        wr(6'h2C, 32'd0);
        wr(6'h10, 32'd5);
        wr(6'h24, 32'h04);
        wr(6'h00, 32'h0);
        idle(20);
        rd(6'h20, 32'h04, "R5 channel 2 fired alone");
        pin(irq, 1'b1, "R8 irq from enabled flag");
        wr(6'h20, 32'h3B);
        rd(6'h20, 32'h04, "R6 zero bits leave flag");
        wr(6'h24, 32'h00);
        idle(2);
        pin(irq, 1'b0, "R8 enable cleared drops irq");
        rd(6'h20, 32'h04, "R8 flag kept while masked");
        wr(6'h24, 32'h04);
        idle(2);
        pin(irq, 1'b1, "R8 enable restored");
        wr(6'h20, 32'h04);
        idle(3);
        pin(irq, 1'b0, "R6 irq after clear");
        rd(6'h20, 32'h0, "R6 flag cleared");
        idle(50);
        rd(6'h20, 32'h0, "R5 passed value does not refire");

        // R5 preset onto compare value does not fire
        wr(6'h2C, 32'd1000);
        wr(6'h0C, 32'h100);
        wr(6'h24, 32'h02);
        wr(6'h00, 32'h100);
        idle(5);
        rd(6'h20, 32'h0, "R5 preset does not fire");
        pin(irq, 1'b0, "R5 irq after preset");

        // R7 hit and clear on the same edge
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h14, 32'd4);
        wr(6'h2C, 32'd0);
        wr(6'h00, 32'h0);
        idle(6);
        wr(6'h20, 32'h08);
        rd(6'h20, 32'h08, "R7 set wins over clear");
        wr(6'h20, 32'h08);
        rd(6'h20, 32'h0, "R6 later clear empties");

        // R9 watchdog
        wr(6'h2C, 32'd1000);
        wr(6'h20, 32'h3F);
        wr(6'h1C, 32'h10);
        wr(6'h28, 32'h0);
        wr(6'h2C, 32'd0);
        wr(6'h00, 32'h0C);
        idle(20);
        rd(6'h20, 32'h20, "R9 channel 5 flag unarmed");
        pin(wdt_rst, 1'b0, "R9 unarmed no reset");
        wr(6'h20, 32'h20);
        wr(6'h28, 32'h1);
        wr(6'h00, 32'h0C);
        idle(20);
        rd(6'h20, 32'h20, "R9 channel 5 flag armed");
        pin(wdt_rst, 1'b1, "R9 armed reset");
        wr(6'h20, 32'h20);
        idle(3);
        pin(wdt_rst, 1'b0, "R9 reset released after clear");

        idle(2);
        summary();
        $finish;
    end
endmodule